// File: doc/BRIEF.md
# I/O Aperture Address Remapper

This block sits between a CPU port and the PCI I/O space. Each CPU request carries an address, a byte count, write data and a write flag. The block turns it into one PCI I/O request. The issued address is the CPU address folded into I/O space and then offset by the I/O base 0x8000_0000.

A mode input selects one of two layouts:

- **Contiguous layout (mode 0).** The address keeps only its low 16 bits, which gives a 64 KB I/O space.
- **Sparse layout (mode 1).** Every 4 KB page of CPU address space collapses onto 32 bytes of I/O. The low five address bits are kept, and the page number (address bits 12 to 26) moves down to bits 5 to 19.

The mode is sampled when a request is accepted. A later change of the mode pin therefore never alters a transfer that is already in flight.

Data moves in little-endian byte order over four byte lanes. Lane k carries the byte at I/O address (issued address + k), and that byte is byte k of the CPU value. Transfers of 1, 2 or 4 bytes are legal at any alignment. Any other byte count is rejected with an error pulse and no downstream transaction. Only one request is in flight at a time. A read completes when the I/O side returns its data, and the block then hands the zero-extended value back to the CPU one cycle later.

Top module: `io_aperture_remap`

## Requirements
- R1: While reset is held and after its release, io_valid, cpu_rvalid and cpu_err are 0 and req_ready is 1.
- R2: With sparse_mode = 0 at acceptance, io_addr = 0x8000_0000 + (req_addr & 0xFFFF), with no alignment applied to the low bits.
- R3: With sparse_mode = 1 at acceptance, io_addr = 0x8000_0000 + ((req_addr & 0x1F) | ((req_addr & 0x07FF_F000) >> 7)), with no alignment applied to the low bits.
- R4: The layout is the value of sparse_mode in the accepting cycle; a change of sparse_mode afterwards leaves the issued io_addr unchanged.
- R5: An accepted legal request drives io_valid for exactly one cycle, on the cycle after acceptance. io_write and io_len copy the request. io_be has bit k set exactly for k < req_len (0x1, 0x3 or 0xF). io_wdata lane k (bits 8k+7:8k) equals req_wdata byte k for enabled lanes and is zero elsewhere.
- R6: For a read, the cycle after rsp_valid, cpu_rvalid pulses and cpu_rdata holds rsp_data lanes 0 to req_len-1 in little-endian order (lane 0 is the least significant byte), zero-extended.
- R7: A request whose req_len is not 1, 2 or 4 pulses cpu_err on the cycle after acceptance and issues no io_valid.
- R8: req_ready is 0 while io_valid is 1 and while a read awaits its response. It returns to 1 in the cycle cpu_rvalid pulses.
- R9: rsp_valid with no read outstanding is ignored: no cpu_rvalid follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sparse_mode | input | 1 | Layout select: 0 contiguous, 1 sparse |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | CPU address in the aperture |
| req_len | input | 3 | Byte count (1, 2 or 4 legal) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write value, least significant byte first on the bus |
| io_valid | output | 1 | One-cycle PCI I/O request strobe |
| io_addr | output | 32 | Remapped I/O address including base |
| io_write | output | 1 | Direction of the I/O request |
| io_len | output | 3 | Byte count of the I/O request |
| io_be | output | 4 | Byte-lane enables |
| io_wdata | output | 32 | Little-endian byte lanes for writes |
| rsp_valid | input | 1 | I/O read data present |
| rsp_data | input | 32 | I/O read byte lanes |
| cpu_rvalid | output | 1 | Read data returned to CPU |
| cpu_rdata | output | 32 | Zero-extended read value |
| cpu_err | output | 1 | Illegal byte count pulse |

## Verification
Some properties are checked by assertions on every cycle:

- An error never coincides with an issued request.
- An issue strobe lasts one cycle, and acceptance is blocked while the strobe is high.
- Byte enables always have one of the three legal shapes.
- Returned read data always follows a response.
- A stray response never produces returned data.

The address folding in both layouts, the lane contents, and the way the mode sample resists a mid-flight change of the mode pin can only be shown by the bench's scenarios. The bench compares these cycle by cycle against its own model, using unaligned addresses, addresses with bits set above the folded range, and every byte count including the illegal ones.

// File: rtl/io_remap_pkg.sv
// Package io_remap_pkg
// Shared constants and helpers for the I/O aperture remapper.
// Assumes byte lanes are eight bits wide.
package io_remap_pkg;

    localparam int unsigned BYTE_W = 8;

    // True when n is a power of two no larger than max_n.
    function automatic logic len_is_legal(input int unsigned n, input int unsigned max_n);
        return (n != 0) && ((n & (n - 1)) == 0) && (n <= max_n);
    endfunction

endpackage

// File: rtl/io_addr_fold.sv
// Module io_addr_fold
// Folds a CPU aperture address into I/O space and adds the I/O base.
// Contiguous layout keeps CONTIG_W low bits. Sparse layout keeps
// SPARSE_LO_W low bits and moves PAGE_BITS page-number bits (starting at
// PAGE_SHIFT) down to sit just above them.
// Assumes SPARSE_LO_W + PAGE_BITS and CONTIG_W both fit in ADDR_W.
module io_addr_fold #(
    parameter int unsigned     ADDR_W      = 32,
    parameter logic [31:0]     IO_BASE     = 32'h8000_0000,
    parameter int unsigned     CONTIG_W    = 16,
    parameter int unsigned     SPARSE_LO_W = 5,
    parameter int unsigned     PAGE_SHIFT  = 12,
    parameter int unsigned     PAGE_BITS   = 15
) (
    input  logic              sparse_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] io_addr_o
);

    localparam logic [ADDR_W-1:0] BASE = IO_BASE[ADDR_W-1:0];

    logic [ADDR_W-1:0] contig_off;
    logic [ADDR_W-1:0] sparse_off;

    // Build the contiguous offset from the low address bits.
    always_comb begin
        contig_off = '0;
        contig_off[CONTIG_W-1:0] = addr_i[CONTIG_W-1:0];
    end

    // Build the sparse offset: low bits stay, page number slides down.
    always_comb begin
        sparse_off = '0;
        sparse_off[SPARSE_LO_W-1:0] = addr_i[SPARSE_LO_W-1:0];
        sparse_off[SPARSE_LO_W +: PAGE_BITS] = addr_i[PAGE_SHIFT +: PAGE_BITS];
    end

    // Select the layout and add the base.
    assign io_addr_o = BASE + (sparse_i ? sparse_off : contig_off);

endmodule

// File: rtl/io_lane_pack.sv
// Module io_lane_pack
// Places a CPU write value on little-endian byte lanes. Lane k receives
// value byte k when k < len_i. Disabled lanes are forced to zero.
// Assumes len_i has already been checked for legality by the caller.
module io_lane_pack #(
    parameter int unsigned LANES = 4,
    parameter int unsigned LEN_W = 3
) (
    input  logic [LEN_W-1:0]                          len_i,
    input  logic [LANES*io_remap_pkg::BYTE_W-1:0]     value_i,
    output logic [LANES*io_remap_pkg::BYTE_W-1:0]     lanes_o,
    output logic [LANES-1:0]                          be_o
);

    localparam int unsigned BW = io_remap_pkg::BYTE_W;

    // One enable and one masked byte per lane.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign be_o[k]              = (int'(len_i) > k);
        assign lanes_o[k*BW +: BW]  = be_o[k] ? value_i[k*BW +: BW] : '0;
    end

endmodule

// File: rtl/io_lane_unpack.sv
// Module io_lane_unpack
// Assembles read byte lanes into a zero-extended little-endian value:
// lane 0 becomes the least significant byte, lanes at or above len_i
// contribute zero.
// Assumes len_i is the byte count of the outstanding read.
module io_lane_unpack #(
    parameter int unsigned LANES = 4,
    parameter int unsigned LEN_W = 3
) (
    input  logic [LEN_W-1:0]                          len_i,
    input  logic [LANES*io_remap_pkg::BYTE_W-1:0]     lanes_i,
    output logic [LANES*io_remap_pkg::BYTE_W-1:0]     value_o
);

    localparam int unsigned BW = io_remap_pkg::BYTE_W;

    // Keep the lanes covered by the read and clear the others.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign value_o[k*BW +: BW] = (int'(len_i) > k) ? lanes_i[k*BW +: BW] : '0;
    end

endmodule

// File: rtl/io_aperture_remap.sv
// Module io_aperture_remap
// Accepts one CPU request at a time and samples the layout mode at
// acceptance. It issues a one-cycle PCI I/O request carrying the folded
// address and little-endian lanes, or pulses an error for an illegal byte
// count. It returns read data one cycle after the I/O response.
// Assumes the I/O side accepts every request strobe and that responses
// arrive only for reads.
module io_aperture_remap #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned LANES       = 4,
    parameter logic [31:0] IO_BASE     = 32'h8000_0000,
    parameter int unsigned CONTIG_W    = 16,
    parameter int unsigned SPARSE_LO_W = 5,
    parameter int unsigned PAGE_SHIFT  = 12,
    parameter int unsigned PAGE_BITS   = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sparse_mode,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [31:0]           req_addr,
    input  logic [2:0]            req_len,
    input  logic                  req_write,
    input  logic [31:0]           req_wdata,
    output logic                  io_valid,
    output logic [31:0]           io_addr,
    output logic                  io_write,
    output logic [2:0]            io_len,
    output logic [3:0]            io_be,
    output logic [31:0]           io_wdata,
    input  logic                  rsp_valid,
    input  logic [31:0]           rsp_data,
    output logic                  cpu_rvalid,
    output logic [31:0]           cpu_rdata,
    output logic                  cpu_err
);

    import io_remap_pkg::*;

    localparam int unsigned DATA_W = LANES * BYTE_W;
    localparam int unsigned LEN_W  = $clog2(LANES) + 1;

    logic [ADDR_W-1:0] fold_addr;
    logic [DATA_W-1:0] pack_lanes;
    logic [LANES-1:0]  pack_be;
    logic [DATA_W-1:0] unpack_val;
    logic              accept;
    logic              legal;
    logic              read_pend;

    // Address folding uses the live mode, so it is captured at acceptance.
    io_addr_fold #(
        .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .CONTIG_W(CONTIG_W),
        .SPARSE_LO_W(SPARSE_LO_W), .PAGE_SHIFT(PAGE_SHIFT), .PAGE_BITS(PAGE_BITS)
    ) u_fold (
        .sparse_i (sparse_mode),
        .addr_i   (req_addr[ADDR_W-1:0]),
        .io_addr_o(fold_addr)
    );

    io_lane_pack #(.LANES(LANES), .LEN_W(LEN_W)) u_pack (
        .len_i  (req_len[LEN_W-1:0]),
        .value_i(req_wdata[DATA_W-1:0]),
        .lanes_o(pack_lanes),
        .be_o   (pack_be)
    );

    io_lane_unpack #(.LANES(LANES), .LEN_W(LEN_W)) u_unpack (
        .len_i  (io_len[LEN_W-1:0]),
        .lanes_i(rsp_data[DATA_W-1:0]),
        .value_o(unpack_val)
    );

    // Acceptance and legality of the offered byte count.
    assign req_ready = !io_valid && !read_pend;
    assign accept    = req_valid && req_ready;
    assign legal     = len_is_legal(int'(req_len), LANES);

    // Strobes for issue and error, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_valid <= 1'b0;
            cpu_err  <= 1'b0;
        end else begin
            io_valid <= accept && legal;
            cpu_err  <= accept && !legal;
        end
    end

    // Capture the request fields, including the folded address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_addr  <= '0;
            io_write <= 1'b0;
            io_len   <= '0;
            io_be    <= '0;
            io_wdata <= '0;
        end else if (accept) begin
            io_addr  <= 32'(fold_addr);
            io_write <= req_write;
            io_len   <= req_len;
            io_be    <= pack_be;
            io_wdata <= 32'(pack_lanes);
        end
    end

    // Track an outstanding read from its issue until its response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            read_pend <= 1'b0;
        end else if (io_valid && !io_write) begin
            read_pend <= 1'b1;
        end else if (rsp_valid) begin
            read_pend <= 1'b0;
        end
    end

    // Return the assembled read value to the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
        end else begin
            cpu_rvalid <= rsp_valid && read_pend;
            if (rsp_valid && read_pend) begin
                cpu_rdata <= 32'(unpack_val);
            end
        end
    end

    AST_ERR_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> !io_valid);                                          // R7
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |=> !io_valid);                                         // R5
    AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> !req_ready);                                        // R8
    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> (io_be == 4'h1 || io_be == 4'h3 || io_be == 4'hF)); // R5
    AST_RDATA_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> $past(rsp_valid));                                // R6
    AST_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && req_ready) |=> !cpu_rvalid);                       // R9

endmodule

// File: tb/test_io_aperture_remap.sv
`timescale 1ns/1ps
module test_io_aperture_remap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sparse_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_len = 3'd1;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        io_valid;
    logic [31:0] io_addr;
    logic        io_write;
    logic [2:0]  io_len;
    logic [3:0]  io_be;
    logic [31:0] io_wdata;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        cpu_err;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    io_aperture_remap i_io_aperture_remap (
        .clk(clk), .rst_n(rst_n), .sparse_mode(sparse_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .req_wdata(req_wdata),
        .io_valid(io_valid), .io_addr(io_addr), .io_write(io_write),
        .io_len(io_len), .io_be(io_be), .io_wdata(io_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err)
    );

    function automatic logic [31:0] byte_mask(input int n);
        logic [31:0] m = '0;
        for (int k = 0; k < 4; k++) if (k < n) m[8*k +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [31:0] expect_addr(input logic [31:0] a, input bit sp);
        if (sp) return 32'h8000_0000 + ((a & 32'h1F) | ((a & 32'h07FF_F000) >> 7));
        return 32'h8000_0000 + (a & 32'hFFFF);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    bit          m_valid, m_err, m_pend, m_rvalid, m_write, m_mode;
    logic [31:0] m_addr, m_wdata, m_rdata;
    int          m_len;
    logic [3:0]  m_be;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 0; m_err <= 0; m_pend <= 0; m_rvalid <= 0;
        end else begin
            automatic bit ready = !m_valid && !m_pend;
            automatic bit acc   = req_valid && ready;
            automatic int n     = int'(req_len);
            automatic bit ok    = (n == 1) || (n == 2) || (n == 4);
            m_valid <= acc && ok;
            m_err   <= acc && !ok;
            if (acc) begin
                m_addr  <= expect_addr(req_addr, sparse_mode);
                m_mode  <= sparse_mode;
                m_write <= req_write;
                m_len   <= n;
                m_be    <= 4'((1 << n) - 1);
                m_wdata <= req_wdata & byte_mask(n);
            end
            if (m_valid && !m_write) m_pend <= 1;
            else if (rsp_valid)      m_pend <= 0;
            m_rvalid <= rsp_valid && m_pend;
            if (rsp_valid && m_pend) m_rdata <= rsp_data & byte_mask(m_len);
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(io_valid == m_valid, "R5 io_valid", 32'(io_valid), 32'(m_valid));
            check(cpu_err == m_err, "R7 cpu_err", 32'(cpu_err), 32'(m_err));
            check(req_ready == (!m_valid && !m_pend), "R8 req_ready", 32'(req_ready), 32'(!m_valid && !m_pend));
            check(cpu_rvalid == m_rvalid, "R9 cpu_rvalid", 32'(cpu_rvalid), 32'(m_rvalid));
            if (m_valid) begin
                check(io_addr == m_addr, m_mode ? "R3 io_addr" : "R2 io_addr", io_addr, m_addr);
                check(io_be == m_be, "R5 io_be", 32'(io_be), 32'(m_be));
                check(io_write == m_write && int'(io_len) == m_len, "R5 io_write/io_len",
                      {28'd0, io_write, io_len}, {28'd0, m_write, 3'(m_len)});
                if (m_write) check(io_wdata == m_wdata, "R5 io_wdata", io_wdata, m_wdata);
            end
            if (m_rvalid) check(cpu_rdata == m_rdata, "R6 cpu_rdata", cpu_rdata, m_rdata);
        end
    end

    // I/O target: answers each read two cycles after its strobe.
    initial begin
        forever begin
            @(negedge clk);
            if (io_valid && !io_write) begin
                automatic logic [31:0] a = io_addr;
                @(negedge clk);
                rsp_valid = 1'b1;
                rsp_data  = (a * 32'h9E37_79B1) ^ 32'hC3A5_5A3C;
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    task automatic send(input logic [31:0] a, input int n, input bit wr,
                        input logic [31:0] d, input bit sp);
        int guard = 0;
        while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
        req_valid = 1'b1; req_addr = a; req_len = 3'(n);
        req_write = wr; req_wdata = d; sparse_mode = sp;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!io_valid && !cpu_rvalid && !cpu_err && req_ready, "R1 reset outputs",
              {28'd0, io_valid, cpu_rvalid, cpu_err, req_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!io_valid && !cpu_err && req_ready, "R1 after release",
              {29'd0, io_valid, cpu_err, req_ready}, 32'h1);

        // R2: contiguous writes, unaligned, bits above 16 discarded
        send(32'h8000_1233, 1, 1, 32'hAABB_CCDD, 0); drain();
        send(32'h8012_FFFF, 4, 1, 32'h1122_3344, 0); drain();
        send(32'h8000_0CF9, 2, 1, 32'hDEAD_BEEF, 0); drain();
        // R3: sparse writes, page folding
        send(32'h8000_3007, 4, 1, 32'h0102_0304, 1); drain();
        send(32'h807F_F01F, 2, 1, 32'hCAFE_F00D, 1); drain();
        send(32'h8765_4321, 1, 1, 32'h5555_5555, 1); drain();
        // R6: reads of each size in both layouts
        send(32'h8000_0CFC, 4, 0, 32'h0, 0); drain();
        send(32'h8000_0071, 1, 0, 32'h0, 0); drain();
        send(32'h8001_2003, 2, 0, 32'h0, 1); drain();
        send(32'h8040_5FFE, 4, 0, 32'h0, 1); drain();
        // R7: illegal byte counts
        send(32'h8000_0010, 0, 1, 32'hFFFF_FFFF, 0); drain();
        send(32'h8000_0011, 3, 0, 32'h0, 1); drain();
        send(32'h8000_0012, 5, 1, 32'h1234_5678, 0); drain();
        send(32'h8000_0013, 7, 1, 32'h1234_5678, 1); drain();
        // R4: mode flips right after acceptance
        send(32'h8002_A00C, 4, 1, 32'h7788_99AA, 1);
        sparse_mode = 1'b0;
        check(io_valid && io_addr == expect_addr(32'h8002_A00C, 1), "R4 mode held",
              io_addr, expect_addr(32'h8002_A00C, 1));
        drain();
        send(32'h8003_B0F0, 2, 0, 32'h0, 0);
        sparse_mode = 1'b1;
        check(io_valid && io_addr == expect_addr(32'h8003_B0F0, 0), "R4 mode held on read",
              io_addr, expect_addr(32'h8003_B0F0, 0));
        drain();
        // R9: stray response with nothing outstanding
        rsp_valid = 1'b1; rsp_data = 32'hFEED_FACE;
        @(negedge clk);
        rsp_valid = 1'b0;
        @(negedge clk);
        check(!cpu_rvalid, "R9 stray response", 32'(cpu_rvalid), 32'h0);
        drain();
        // R8: back-to-back offers, second must wait for read completion
        send(32'h8000_0400, 4, 0, 32'h0, 0);
        check(!req_ready, "R8 busy during read", 32'(req_ready), 32'h0);
        send(32'h8000_0404, 4, 1, 32'h0BAD_CAFE, 0); drain();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++; fails++;
            $display("FAIL R8 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule